// File: doc/BRIEF.md
# Multi-Cycle Execute Stall Controller

This block is the control skeleton of a four-stage in-order instruction pipeline. The stages are Fetch, Decode, Execute and Write. Each stage register holds a valid bit and a payload. In the first three stages the payload is an instruction token plus a 2-bit operation class. In Write it is the token alone. The Execute unit has no datapath. It is a latency timer that the operation class programs.

An operation that needs more than one Execute cycle raises `stall`. While `stall` is high, the Fetch, Decode and Execute registers hold their contents, because their enables are separate from the clock. `in_ready` drops so that the source keeps presenting the same instruction. The Write register keeps clocking and is loaded with an invalid bubble, so nothing is written back until the long operation leaves Execute. When `stall` falls, all held registers advance on the same edge. Tokens retire in program order through `wb_strobe` and `wb_token`.

The timer is a state machine with three states:
- `EX_IDLE`: Execute is empty.
- `EX_RUN`: a multi-cycle operation is still working, and `stall` is high.
- `EX_LAST`: the operation in Execute is in its final or only cycle.

It has these transitions:
- idle-to-run, or last-to-run: a multi-cycle operation is loaded.
- idle-to-last, or last-to-last: a single-cycle operation is loaded.
- run-to-run: the counter is not yet zero.
- run-to-last: the counter reaches zero.
- last-to-idle, or idle-to-idle: nothing valid enters Execute.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every stage valid bit and the latency timer. After reset, `stage_occ` is 0, `wb_strobe` is 0, `stall` is 0 and `in_ready` is 1.
- R2: An operation of class 0 spends one cycle in Execute. If it is accepted on clock edge a, it is presented on `wb_strobe`/`wb_token` after edge a+3.
- R3: An operation of class 1 spends three consecutive cycles in Execute. If it is accepted on edge a, it retires after edge a+5, and `stall` is high for exactly two cycles.
- R4: During every cycle in which `stall` is high, the Write stage is loaded with a bubble. `wb_strobe` is therefore 0 in the cycle after any stall cycle.
- R5: While `stall` is high, `in_ready` is 0 and the Fetch, Decode and Execute occupancy bits hold their values. `stage_occ` bit 0 is Fetch, bit 1 is Decode, bit 2 is Execute and bit 3 is Write.
- R6: Every accepted token retires exactly once, in acceptance order, with no loss and no duplication. Each long operation adds its extra Execute cycles to the stream.
- R7: Long operations that follow each other each take their full latency in turn. Execute never holds two instructions, and `stall` only occurs with the Execute bit of `stage_occ` set.
- R8: Class 2 spends two Execute cycles and retires after edge a+4. Class 3 spends four Execute cycles and retires after edge a+6.
- R9: A reset asserted while `stall` is high discards all in-flight instructions. No token that was in flight is written back afterwards.
- R10: A cycle with `in_valid` low enters the pipeline as a bubble. The bubble never causes a stall, whatever `in_opc` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming instruction is present |
| in_token | input | TOKEN_W | Tag of the incoming instruction |
| in_opc | input | 2 | Operation class selecting the Execute latency |
| in_ready | output | 1 | Fetch accepts the incoming instruction on this edge |
| stall | output | 1 | Execute is busy with a multi-cycle operation |
| stage_occ | output | 4 | Valid bits of Fetch, Decode, Execute and Write (bit 0 to bit 3) |
| wb_strobe | output | 1 | Write stage holds a retiring instruction |
| wb_token | output | TOKEN_W | Token of the retiring instruction |

## Verification
The assertions assume that the source only counts an instruction as taken on an edge where `in_ready` was high, and that reset is held for at least one edge before any stimulus. The bench meets both conditions. It drives all inputs at the falling edge, and it keeps an instruction on the inputs until it has seen `in_ready` high just before a rising edge. It also raises reset at time zero and holds it for several cycles. Tokens go into the reference queue only when they are accepted, so retire order and count are measured against what the block actually took in.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

    localparam int OPC_W      = 2;
    localparam int NUM_STAGES = 4;

    localparam int STG_F = 0;
    localparam int STG_D = 1;
    localparam int STG_E = 2;
    localparam int STG_W = 3;

    typedef enum logic [1:0] {
        EX_IDLE = 2'd0,
        EX_RUN  = 2'd1,
        EX_LAST = 2'd2
    } ex_state_e;

endpackage

// File: rtl/pipe_hold_reg.sv
module pipe_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (en) begin
            q_valid <= d_valid;
            q_data  <= d_data;
        end
    end

endmodule

// File: rtl/pipe_exec_timer.sv
module pipe_exec_timer
    import pipe_pkg::*;
#(
    parameter int LAT_C0 = 1,
    parameter int LAT_C1 = 3,
    parameter int LAT_C2 = 2,
    parameter int LAT_C3 = 4,
    parameter int CNT_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OPC_W-1:0] load_opc,
    output logic             stall
);

    ex_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    int               lat;

    always_comb begin
        unique case (load_opc)
            2'd0: lat = LAT_C0;
            2'd1: lat = LAT_C1;
            2'd2: lat = LAT_C2;
            default: lat = LAT_C3;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            EX_IDLE, EX_LAST: begin
                if (load && lat > 1) begin
                    state_d = EX_RUN;
                    cnt_d   = CNT_W'(lat - 2);
                end else if (load) begin
                    state_d = EX_LAST;
                end else begin
                    state_d = EX_IDLE;
                end
            end
            EX_RUN: begin
                if (cnt_q == '0) begin
                    state_d = EX_LAST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = EX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        stall = (state_q == EX_RUN);
    end

endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl
    import pipe_pkg::*;
#(
    parameter int TOKEN_W = 8,
    parameter int LAT_C0  = 1,
    parameter int LAT_C1  = 3,
    parameter int LAT_C2  = 2,
    parameter int LAT_C3  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [TOKEN_W-1:0]    in_token,
    input  logic [OPC_W-1:0]      in_opc,
    output logic                  in_ready,
    output logic                  stall,
    output logic [NUM_STAGES-1:0] stage_occ,
    output logic                  wb_strobe,
    output logic [TOKEN_W-1:0]    wb_token
);

    localparam int PAY_W   = TOKEN_W + OPC_W;
    localparam int MAX_A   = (LAT_C0 > LAT_C1) ? LAT_C0 : LAT_C1;
    localparam int MAX_B   = (LAT_C2 > LAT_C3) ? LAT_C2 : LAT_C3;
    localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;

    logic             advance;
    logic [STG_W-1:0] up_valid;
    logic [PAY_W-1:0] up_pay [STG_W];
    logic             w_valid;
    logic [TOKEN_W-1:0] w_token;

    assign advance  = ~stall;
    assign in_ready = advance;

    // Fetch, Decode and Execute registers: frozen while Execute is busy
    generate
        for (genvar i = 0; i < STG_W; i++) begin : g_up
            if (i == STG_F) begin : g_first
                pipe_hold_reg #(.W(PAY_W)) u_reg (
                    .clk     (clk),
                    .rst     (rst),
                    .en      (advance),
                    .d_valid (in_valid),
                    .d_data  ({in_token, in_opc}),
                    .q_valid (up_valid[i]),
                    .q_data  (up_pay[i])
                );
            end else begin : g_next
                pipe_hold_reg #(.W(PAY_W)) u_reg (
                    .clk     (clk),
                    .rst     (rst),
                    .en      (advance),
                    .d_valid (up_valid[i-1]),
                    .d_data  (up_pay[i-1]),
                    .q_valid (up_valid[i]),
                    .q_data  (up_pay[i])
                );
            end
        end
    endgenerate

    // Write register: always clocks, takes a bubble while stalled
    pipe_hold_reg #(.W(TOKEN_W)) u_wreg (
        .clk     (clk),
        .rst     (rst),
        .en      (1'b1),
        .d_valid (up_valid[STG_E] & advance),
        .d_data  (up_pay[STG_E][PAY_W-1:OPC_W]),
        .q_valid (w_valid),
        .q_data  (w_token)
    );

    pipe_exec_timer #(
        .LAT_C0 (LAT_C0),
        .LAT_C1 (LAT_C1),
        .LAT_C2 (LAT_C2),
        .LAT_C3 (LAT_C3),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (advance & up_valid[STG_D]),
        .load_opc (up_pay[STG_D][OPC_W-1:0]),
        .stall    (stall)
    );

    assign stage_occ = {w_valid, up_valid};
    assign wb_strobe = w_valid;
    assign wb_token  = w_token;

endmodule

// File: rtl/pipe_stall_ctrl_chk.sv
module pipe_stall_ctrl_chk #(
    parameter int MAX_LAT = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       stall,
    input logic [3:0] stage_occ,
    input logic       wb_strobe
);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst)        run_cnt <= 0;
        else if (stall) run_cnt <= run_cnt + 1;
        else            run_cnt <= 0;
    end

    // R4: stalled cycle sends a bubble to Write
    a_r4_bubble_to_write: assert property (@(posedge clk) disable iff (rst)
        stall |=> !wb_strobe);

    // R5: upstream occupancy frozen during stall
    a_r5_hold_upstream: assert property (@(posedge clk) disable iff (rst)
        stall |=> stage_occ[2:0] == $past(stage_occ[2:0]));

    // R5: no acceptance while stalled
    a_r5_ready_blocked: assert property (@(posedge clk) disable iff (rst)
        stall |=> $past(in_ready) == 1'b0);

    // R7: a stall only with an instruction in Execute
    a_r7_stall_has_exec: assert property (@(posedge clk) disable iff (rst)
        stall |-> stage_occ[2]);

    // R7: a stall run never exceeds the longest latency minus one
    a_r7_stall_bounded: assert property (@(posedge clk) disable iff (rst)
        stall |-> run_cnt < MAX_LAT - 1);

    // R2: an unstalled Execute occupant reaches Write next cycle
    a_r2_exec_retires: assert property (@(posedge clk) disable iff (rst)
        (stage_occ[2] && !stall) |=> wb_strobe);

endmodule

bind pipe_stall_ctrl pipe_stall_ctrl_chk #(.MAX_LAT(MAX_LAT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .stall     (stall),
    .stage_occ (stage_occ),
    .wb_strobe (wb_strobe)
);

// File: tb/pipe_stall_ctrl_tb.sv
module pipe_stall_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_token = '0;
    logic [1:0] in_opc = '0;
    logic       in_ready, stall, wb_strobe;
    logic [3:0] stage_occ;
    logic [7:0] wb_token;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_wb_cyc = -1;
    int wb_count = 0;
    logic [7:0] ref_q [$];
    logic       prev_stall = 1'b0;
    logic [2:0] prev_occ = '0;

    pipe_stall_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_token  (in_token),
        .in_opc    (in_opc),
        .in_ready  (in_ready),
        .stall     (stall),
        .stage_occ (stage_occ),
        .wb_strobe (wb_strobe),
        .wb_token  (wb_token)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // retire monitor against reference queue (R6)
    always @(negedge clk) begin
        if (!rst && wb_strobe) begin
            if (ref_q.size() == 0) begin
                check(1'b0, "R6 unexpected retire", int'(wb_token), -1);
            end else begin
                logic [7:0] exp_tok;
                exp_tok = ref_q.pop_front();
                check(wb_token == exp_tok, "R6 retire order", int'(wb_token), int'(exp_tok));
            end
            last_wb_cyc = cyc;
            wb_count++;
        end
    end

    // stall behaviour monitor (R5, R4)
    always @(negedge clk) begin
        if (!rst) begin
            if (stall) check(in_ready == 1'b0, "R5 ready during stall", int'(in_ready), 0);
            if (prev_stall) begin
                check(stage_occ[2:0] == prev_occ, "R5 upstream hold", int'(stage_occ[2:0]), int'(prev_occ));
                check(wb_strobe == 1'b0, "R4 bubble after stall", int'(wb_strobe), 0);
            end
            prev_stall = stall;
            prev_occ   = stage_occ[2:0];
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic send(input logic [7:0] tok, input logic [1:0] opc, output int acc);
        bit got;
        in_valid = 1'b1;
        in_token = tok;
        in_opc   = opc;
        while (1) begin
            got = in_ready;
            @(posedge clk);
            @(negedge clk);
            if (got) break;
        end
        acc = cyc;
        ref_q.push_back(tok);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ref_q.delete();
        check(stage_occ == 4'b0, "R1 occupancy", int'(stage_occ), 0);
        check(wb_strobe == 1'b0, "R1 strobe", int'(wb_strobe), 0);
        check(stall == 1'b0, "R1 stall", int'(stall), 0);
        check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    endtask

    task automatic t_latency(input logic [7:0] tok, input logic [1:0] opc,
                             input int lat, input string req);
        int acc, n0, stalls;
        n0 = wb_count;
        stalls = 0;
        send(tok, opc, acc);
        repeat (lat + 4) begin
            if (stall) stalls++;
            @(negedge clk);
        end
        check(last_wb_cyc == acc + 2 + lat, req, last_wb_cyc - acc, 2 + lat);
        check(wb_count == n0 + 1, req, wb_count - n0, 1);
        check(stalls == lat - 1, req, stalls, lat - 1);
    endtask

    task automatic t_stream;
        logic [1:0] pat [8] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0};
        int acc0, acc, n0;
        n0 = wb_count;
        for (int i = 0; i < 8; i++) begin
            send(8'h30 + 8'(i), pat[i], acc);
            if (i == 0) acc0 = acc;
        end
        idle(12);
        // R6 / R7: 8 retires, 3 long ops each add 2 cycles
        check(wb_count == n0 + 8, "R6 stream count", wb_count - n0, 8);
        check(ref_q.size() == 0, "R6 queue drained", ref_q.size(), 0);
        check(last_wb_cyc == acc0 + 16, "R7 stream timing", last_wb_cyc - acc0, 16);
    endtask

    task automatic t_bubble;
        int saw_stall, saw_wb, n0;
        saw_stall = 0;
        saw_wb = 0;
        n0 = wb_count;
        in_valid = 1'b0;
        in_opc = 2'd3;
        repeat (8) begin
            @(negedge clk);
            if (stall) saw_stall++;
        end
        check(saw_stall == 0, "R10 bubble no stall", saw_stall, 0);
        check(wb_count == n0, "R10 bubble no retire", wb_count - n0, 0);
        t_latency(8'h51, 2'd0, 1, "R10 single after bubbles");
    endtask

    task automatic t_reset_mid;
        int acc, n0;
        send(8'h61, 2'd3, acc);
        while (!stall) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_q.delete();
        n0 = wb_count;
        check(stage_occ == 4'b0, "R9 occupancy cleared", int'(stage_occ), 0);
        check(stall == 1'b0, "R9 stall cleared", int'(stall), 0);
        idle(8);
        check(wb_count == n0, "R9 no stale retire", wb_count - n0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_latency(8'h11, 2'd0, 1, "R2 class0 latency");
        t_latency(8'h22, 2'd1, 3, "R3 class1 latency");
        t_latency(8'h23, 2'd2, 2, "R8 class2 latency");
        t_latency(8'h24, 2'd3, 4, "R8 class3 latency");
        t_stream();
        t_bubble();
        t_reset_mid();
        t_latency(8'h71, 2'd1, 3, "R3 after reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule